// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block steers operands into the execute stage of a five-stage pipeline. The instruction in the decode stage names up to two source registers. For each one, the unit chooses a value from four places. It can take the register-file read, or it can take a newer result that an older instruction has produced but not yet written back. There are three such newer results: the combinational ALU output of the instruction now in execute, result register C, which belongs to the instruction one stage past execute, and result register C1, which belongs to the instruction in write-back. The chosen value is captured into operand register A or B on the clock edge, and the unit records which source fed it. The C register carries the finished result of its instruction, so a load's data is already there.

The ALU output of a load is an address, not data. A source that matches a load in execute therefore raises a stall request. The pipeline holds the consumer in decode for one cycle, and on the next cycle the value is taken from C. Forwarding can be switched off. The unit then always reads the register file, and it requests a stall for as long as any older in-flight instruction is going to write one of the consumer's sources. That is plain interlocking.

Top module: `fwd_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `op_vld`, `sela`, `selb`, `opa` and `opb` are all zero.
- R2: A used source that matches no writing producer is loaded from its register-file read, and its select code reads 0. The operand register and its code change on the clock edge after the consumer is presented with `id_vld` high and `stall` low, and `op_vld` is 1 after that edge.
- R3: With forwarding on, a used source that equals `ex_rd` while `ex_wr` is 1 and `ex_load` is 0 loads `ex_alu`, and its select code reads 1.
- R4: With forwarding on, a used source that matches `me_rd` (with `me_wr` 1) and does not match the execute producer loads `me_c`, and its select code reads 2.
- R5: With forwarding on, a used source that matches only `wb_rd` (with `wb_wr` 1) loads `wb_c1`, and its select code reads 3.
- R6: When several producers match, the youngest one wins. The ALU output comes first, then C, then C1.
- R7: Source register 0, a producer whose write flag is 0, and a source whose use flag is 0 never cause forwarding or a stall. Such an operand is loaded from the register file with select code 0.
- R8: With forwarding on, `stall` is 1 in the same cycle when a used source matches a writing load in execute. On the next edge, `op_vld` goes to 0 and A, B, `sela` and `selb` keep their values.
- R9: With forwarding off, select codes are always 0. `stall` is 1 whenever a used nonzero source matches any writing producer in execute, C or C1.
- R10: With `id_vld` at 0, `stall` is 0. On the next edge, `op_vld` goes to 0 and the operand registers and select codes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 turns forwarding on, 0 selects plain interlocking |
| id_vld | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | RIDX | First source register number |
| id_use1 | input | 1 | First source is read |
| id_rs2 | input | RIDX | Second source register number |
| id_use2 | input | 1 | Second source is read |
| rf_rd1 | input | XLEN | Register-file value for the first source |
| rf_rd2 | input | XLEN | Register-file value for the second source |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_rd | input | RIDX | Destination of the instruction in execute |
| ex_load | input | 1 | Instruction in execute is a load |
| ex_alu | input | XLEN | Current ALU output |
| me_wr | input | 1 | Owner of C writes a register |
| me_rd | input | RIDX | Destination of the owner of C |
| me_c | input | XLEN | Result register C |
| wb_wr | input | 1 | Owner of C1 writes a register |
| wb_rd | input | RIDX | Destination of the owner of C1 |
| wb_c1 | input | XLEN | Result register C1 |
| stall | output | 1 | Hold the consumer in decode this cycle |
| op_vld | output | 1 | Operand registers were loaded on the last edge |
| opa | output | XLEN | Operand register A |
| opb | output | XLEN | Operand register B |
| sela | output | 2 | Source of A: 0 register file, 1 ALU, 2 C, 3 C1 |
| selb | output | 2 | Source of B, same code |

## Verification
On every cycle, the checker confirms several properties. With forwarding on, a stall always comes from a writing load in execute. An idle decode stage never stalls. A stalled cycle leaves both operands untouched. Register 0 and a disabled unit always give select code 0. An operand marked as coming from the ALU holds the ALU value of the previous cycle. The bench scenarios cover the rest. They show the full priority order when all three producers carry the same destination, and the two-cycle load-use sequence in which the stalled consumer then picks up C. They also cover the masking effect of a cleared use or write flag, and interlocking against C and C1 when forwarding is off.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_ALU = 2'd1,
    SRC_C   = 2'd2,
    SRC_C1  = 2'd3
  } src_e;

  // producers, youngest first: execute, C owner, C1 owner
  localparam int NPROD = 3;
  localparam int NOPR  = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int RIDX = 5
) (
  input  logic [RIDX-1:0] src,
  input  logic            use_i,
  input  logic            prod_wr,
  input  logic [RIDX-1:0] prod_rd,
  output logic            hit
);
  // register 0 is hardwired, never a dependency
  assign hit = use_i && prod_wr && (src != '0) && (src == prod_rd);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int RIDX = 5
) (
  input  logic            fwd_en,
  input  logic [RIDX-1:0] src,
  input  logic            use_i,
  input  logic            ex_wr,
  input  logic [RIDX-1:0] ex_rd,
  input  logic            ex_load,
  input  logic            me_wr,
  input  logic [RIDX-1:0] me_rd,
  input  logic            wb_wr,
  input  logic [RIDX-1:0] wb_rd,
  output src_e            sel,
  output logic            need_stall
);
  logic [NPROD-1:0] pw;
  logic [RIDX-1:0]  pr [NPROD];
  logic [NPROD-1:0] hit;

  assign pw    = {wb_wr, me_wr, ex_wr};
  assign pr[0] = ex_rd;
  assign pr[1] = me_rd;
  assign pr[2] = wb_rd;

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    fwd_match #(.RIDX(RIDX)) u_match (
      .src    (src),
      .use_i  (use_i),
      .prod_wr(pw[p]),
      .prod_rd(pr[p]),
      .hit    (hit[p])
    );
  end

  always_comb begin
    sel        = SRC_RF;
    need_stall = 1'b0;
    if (fwd_en) begin
      if (hit[0]) begin
        sel        = SRC_ALU;
        need_stall = ex_load;
      end else if (hit[1]) begin
        sel = SRC_C;
      end else if (hit[2]) begin
        sel = SRC_C1;
      end
    end else begin
      need_stall = |hit;
    end
  end
endmodule

// File: rtl/fwd_opreg.sv
module fwd_opreg
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  src_e            sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] alu_val,
  input  logic [XLEN-1:0] c_val,
  input  logic [XLEN-1:0] c1_val,
  output logic [XLEN-1:0] q,
  output logic [1:0]      q_sel
);
  logic [XLEN-1:0] nxt;

  always_comb begin
    unique case (sel)
      SRC_ALU: nxt = alu_val;
      SRC_C:   nxt = c_val;
      SRC_C1:  nxt = c1_val;
      default: nxt = rf_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      q_sel <= 2'd0;
    end else if (load) begin
      q     <= nxt;
      q_sel <= sel;
    end
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fwd_en,
  input  logic            id_vld,
  input  logic [RIDX-1:0] id_rs1,
  input  logic            id_use1,
  input  logic [RIDX-1:0] id_rs2,
  input  logic            id_use2,
  input  logic [XLEN-1:0] rf_rd1,
  input  logic [XLEN-1:0] rf_rd2,
  input  logic            ex_wr,
  input  logic [RIDX-1:0] ex_rd,
  input  logic            ex_load,
  input  logic [XLEN-1:0] ex_alu,
  input  logic            me_wr,
  input  logic [RIDX-1:0] me_rd,
  input  logic [XLEN-1:0] me_c,
  input  logic            wb_wr,
  input  logic [RIDX-1:0] wb_rd,
  input  logic [XLEN-1:0] wb_c1,
  output logic            stall,
  output logic            op_vld,
  output logic [XLEN-1:0] opa,
  output logic [XLEN-1:0] opb,
  output logic [1:0]      sela,
  output logic [1:0]      selb
);
  logic [RIDX-1:0] rs   [NOPR];
  logic [NOPR-1:0] uses;
  logic [XLEN-1:0] rfv  [NOPR];
  logic [XLEN-1:0] q    [NOPR];
  logic [1:0]      qs   [NOPR];
  src_e            sel  [NOPR];
  logic [NOPR-1:0] stl;
  logic            take;

  assign rs[0]  = id_rs1;
  assign rs[1]  = id_rs2;
  assign uses   = {id_use2, id_use1};
  assign rfv[0] = rf_rd1;
  assign rfv[1] = rf_rd2;

  assign stall = id_vld && (|stl);
  assign take  = id_vld && !stall;

  for (genvar k = 0; k < NOPR; k++) begin : g_opr
    fwd_pick #(.RIDX(RIDX)) u_pick (
      .fwd_en    (fwd_en),
      .src       (rs[k]),
      .use_i     (uses[k]),
      .ex_wr     (ex_wr),
      .ex_rd     (ex_rd),
      .ex_load   (ex_load),
      .me_wr     (me_wr),
      .me_rd     (me_rd),
      .wb_wr     (wb_wr),
      .wb_rd     (wb_rd),
      .sel       (sel[k]),
      .need_stall(stl[k])
    );

    fwd_opreg #(.XLEN(XLEN)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .load   (take),
      .sel    (sel[k]),
      .rf_val (rfv[k]),
      .alu_val(ex_alu),
      .c_val  (me_c),
      .c1_val (wb_c1),
      .q      (q[k]),
      .q_sel  (qs[k])
    );
  end

  assign opa  = q[0];
  assign opb  = q[1];
  assign sela = qs[0];
  assign selb = qs[1];

  always_ff @(posedge clk) begin
    if (rst) op_vld <= 1'b0;
    else     op_vld <= take;
  end
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            fwd_en,
  input logic            id_vld,
  input logic [RIDX-1:0] id_rs1,
  input logic            ex_wr,
  input logic            ex_load,
  input logic [XLEN-1:0] ex_alu,
  input logic            stall,
  input logic            op_vld,
  input logic [XLEN-1:0] opa,
  input logic [XLEN-1:0] opb,
  input logic [1:0]      sela,
  input logic [1:0]      selb
);
  // R8: with forwarding on, only a writing load in execute can stall
  assert_stall_load_R8: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && stall) |-> (ex_wr && ex_load));

  // R10: an empty decode stage never stalls
  assert_idle_nostall_R10: assert property (@(posedge clk) disable iff (rst)
    !id_vld |-> !stall);

  // R8: operands and codes frozen across a stalled cycle
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!op_vld && $stable(opa) && $stable(opb) && $stable(sela) && $stable(selb)));

  // R7: register 0 always comes from the register file
  assert_r0_rf_R7: assert property (@(posedge clk) disable iff (rst)
    (id_vld && !stall && id_rs1 == '0) |=> (sela == 2'd0));

  // R9: disabled forwarding gives register-file codes only
  assert_off_rf_R9: assert property (@(posedge clk) disable iff (rst)
    (id_vld && !stall && !fwd_en) |=> (sela == 2'd0 && selb == 2'd0));

  // R3: an ALU-sourced operand holds the ALU value of the loading cycle
  assert_alu_value_R3: assert property (@(posedge clk) disable iff (rst)
    (op_vld && sela == 2'd1) |-> (opa == $past(ex_alu)));

  // R2: op_vld only after an accepted consumer
  assert_vld_origin_R2: assert property (@(posedge clk) disable iff (rst)
    op_vld |-> $past(id_vld && !stall));
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .fwd_en (fwd_en),
  .id_vld (id_vld),
  .id_rs1 (id_rs1),
  .ex_wr  (ex_wr),
  .ex_load(ex_load),
  .ex_alu (ex_alu),
  .stall  (stall),
  .op_vld (op_vld),
  .opa    (opa),
  .opb    (opb),
  .sela   (sela),
  .selb   (selb)
);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwd_en = 1'b1, id_vld = 1'b0, id_use1 = 1'b0, id_use2 = 1'b0;
  logic [RIDX-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, me_rd = '0, wb_rd = '0;
  logic [XLEN-1:0] rf_rd1 = '0, rf_rd2 = '0, ex_alu = '0, me_c = '0, wb_c1 = '0;
  logic ex_wr = 1'b0, ex_load = 1'b0, me_wr = 1'b0, wb_wr = 1'b0;
  logic stall, op_vld;
  logic [XLEN-1:0] opa, opb;
  logic [1:0] sela, selb;

  always #5 clk = ~clk;

  fwd_unit #(.XLEN(XLEN), .RIDX(RIDX)) i_fwd_unit (
    .clk(clk), .rst(rst), .fwd_en(fwd_en), .id_vld(id_vld),
    .id_rs1(id_rs1), .id_use1(id_use1), .id_rs2(id_rs2), .id_use2(id_use2),
    .rf_rd1(rf_rd1), .rf_rd2(rf_rd2),
    .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_load(ex_load), .ex_alu(ex_alu),
    .me_wr(me_wr), .me_rd(me_rd), .me_c(me_c),
    .wb_wr(wb_wr), .wb_rd(wb_rd), .wb_c1(wb_c1),
    .stall(stall), .op_vld(op_vld), .opa(opa), .opb(opb), .sela(sela), .selb(selb)
  );

  typedef struct packed {
    logic            v;
    logic [1:0]      sa;
    logic [1:0]      sb;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int checks = 0, errors = 0, n = 0;
  bit done = 0;
  exp_t model = '0;

  // expected source code for one operand, derived from R3..R7, R9
  function automatic logic [1:0] want_sel(logic u, logic [RIDX-1:0] r);
    if (!u || r == 0 || !fwd_en) return 2'd0;
    if (ex_wr && ex_rd == r) return 2'd1;
    if (me_wr && me_rd == r) return 2'd2;
    if (wb_wr && wb_rd == r) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic want_stall_one(logic u, logic [RIDX-1:0] r);
    logic m_ex, m_me, m_wb;
    if (!u || r == 0) return 1'b0;
    m_ex = ex_wr && ex_rd == r;
    m_me = me_wr && me_rd == r;
    m_wb = wb_wr && wb_rd == r;
    if (fwd_en) return m_ex && ex_load;
    return m_ex || m_me || m_wb;
  endfunction

  function automatic logic [XLEN-1:0] val_of(logic [1:0] s, logic [XLEN-1:0] rf);
    case (s)
      2'd1: return ex_alu;
      2'd2: return me_c;
      2'd3: return wb_c1;
      default: return rf;
    endcase
  endfunction

  task automatic drive(input logic en, input logic vld,
                       input logic [RIDX-1:0] r1, input logic u1,
                       input logic [RIDX-1:0] r2, input logic u2,
                       input logic ew, input logic [RIDX-1:0] erd, input logic eld,
                       input logic mw, input logic [RIDX-1:0] mrd,
                       input logic ww, input logic [RIDX-1:0] wrd,
                       input string tag);
    logic es;
    @(negedge clk);
    n++;
    fwd_en = en; id_vld = vld;
    id_rs1 = r1; id_use1 = u1; id_rs2 = r2; id_use2 = u2;
    ex_wr = ew; ex_rd = erd; ex_load = eld;
    me_wr = mw; me_rd = mrd; wb_wr = ww; wb_rd = wrd;
    rf_rd1 = 32'h1100_0000 + n; rf_rd2 = 32'h2200_0000 + n;
    ex_alu = 32'hAA00_0000 + n; me_c = 32'hCC00_0000 + n; wb_c1 = 32'hC100_0000 + n;
    #1;
    es = vld && (want_stall_one(u1, r1) || want_stall_one(u2, r2));
    checks++;
    if (stall !== es) begin
      errors++;
      $display("FAIL %s stall: actual %0b expected %0b", tag, stall, es);
    end
    if (vld && !es) begin
      model.sa = want_sel(u1, r1);
      model.sb = want_sel(u2, r2);
      model.a  = val_of(model.sa, rf_rd1);
      model.b  = val_of(model.sb, rf_rd2);
      model.v  = 1'b1;
    end else begin
      model.v = 1'b0;
    end
    sb_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor: compare each pushed item just after the edge that loads it
  always @(posedge clk) begin
    exp_t  e;
    string t;
    #2;
    if (!rst && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (op_vld !== e.v || sela !== e.sa || selb !== e.sb || opa !== e.a || opb !== e.b) begin
        errors++;
        $display("FAIL %s: actual v=%0b sa=%0d sb=%0d a=%h b=%h expected v=%0b sa=%0d sb=%0d a=%h b=%h",
                 t, op_vld, sela, selb, opa, opb, e.v, e.sa, e.sb, e.a, e.b);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values held in reset
    checks++;
    if (op_vld !== 0 || opa !== 0 || opb !== 0 || sela !== 0 || selb !== 0) begin
      errors++;
      $display("FAIL R1 reset: actual v=%0b a=%h b=%h sa=%0d sb=%0d expected all zero",
               op_vld, opa, opb, sela, selb);
    end
    rst = 1'b0;

    // R2: no dependency
    drive(1, 1, 5'd3, 1, 5'd4, 1, 1, 5'd5, 0, 1, 5'd6, 1, 5'd7, "R2 no hazard");
    // R3, R4: A from ALU, B from C
    drive(1, 1, 5'd5, 1, 5'd6, 1, 1, 5'd5, 0, 1, 5'd6, 1, 5'd7, "R3 R4 alu and c");
    // R5: A from C1
    drive(1, 1, 5'd7, 1, 5'd9, 1, 1, 5'd5, 0, 1, 5'd6, 1, 5'd7, "R5 from c1");
    // R6: all three producers write r8
    drive(1, 1, 5'd8, 1, 5'd8, 1, 1, 5'd8, 0, 1, 5'd8, 1, 5'd8, "R6 alu wins");
    drive(1, 1, 5'd9, 1, 5'd9, 1, 1, 5'd2, 0, 1, 5'd9, 1, 5'd9, "R6 c over c1");
    // R7: r0, non-writing producer, unused operand
    drive(1, 1, 5'd0, 1, 5'd0, 1, 1, 5'd0, 1, 1, 5'd0, 1, 5'd0, "R7 reg zero");
    drive(1, 1, 5'd5, 1, 5'd6, 0, 0, 5'd5, 0, 1, 5'd6, 0, 5'd7, "R7 no write or unused");
    drive(1, 1, 5'd3, 1, 5'd5, 0, 1, 5'd5, 1, 0, 5'd0, 0, 5'd0, "R7 unused load match");
    // R8: load-use, then pick up from C
    drive(1, 1, 5'd5, 1, 5'd4, 1, 1, 5'd5, 1, 0, 5'd0, 0, 5'd0, "R8 load-use stall");
    drive(1, 1, 5'd5, 1, 5'd4, 1, 0, 5'd0, 0, 1, 5'd5, 0, 5'd0, "R8 after stall from c");
    drive(1, 1, 5'd2, 1, 5'd6, 1, 1, 5'd6, 1, 0, 5'd0, 0, 5'd0, "R8 load-use on b");
    // R9: forwarding off
    drive(0, 1, 5'd5, 1, 5'd4, 1, 0, 5'd0, 0, 1, 5'd5, 0, 5'd0, "R9 off stall on c");
    drive(0, 1, 5'd4, 1, 5'd7, 1, 0, 5'd0, 0, 0, 5'd0, 1, 5'd7, "R9 off stall on c1");
    drive(0, 1, 5'd5, 1, 5'd4, 1, 1, 5'd5, 0, 0, 5'd0, 0, 5'd0, "R9 off stall on alu");
    drive(0, 1, 5'd5, 1, 5'd4, 1, 0, 5'd5, 0, 0, 5'd5, 0, 5'd5, "R9 off no match");
    // R10: idle decode with matching producer
    drive(1, 0, 5'd5, 1, 5'd5, 1, 1, 5'd5, 1, 1, 5'd5, 1, 5'd5, "R10 idle");
    drive(1, 1, 5'd1, 1, 5'd2, 1, 0, 5'd0, 0, 0, 5'd0, 0, 5'd0, "R2 after idle");

    @(negedge clk);
    id_vld = 1'b0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule